// File: doc/BRIEF.md
# MSI and Legacy Interrupt Generator

This block turns interrupt requests from the application logic of a PCI Express endpoint into one of two link-level signals. The signal is either a level on a legacy INTx status output or a Message Signaled Interrupt. The choice follows configuration state: the MSI enable bit of the MSI capability header. Out of reset that bit is clear, so the block works in legacy mode. Only one mechanism is active at any time.

In MSI mode a held request produces one posted memory write carrying a single data dword. The write goes to the address software programmed and carries the programmed message data. The traffic class and the vector number come from inputs presented with the request. The write leaves as a stream of 32-bit beats under a valid/ready handshake. The application gets a one-cycle acknowledge once the final beat has been accepted. In legacy mode the request level is reflected on the status output, unless the command register masks it.

Top module: `msi_intx_gen`

## Requirements
- R1: While the reset input is low, and for the two clocks after it rises, irq_ack, tlp_valid and intx_sts are all low.
- R2: With msi_cap_hdr[16] clear, intx_sts equals irq_req as sampled at the previous clock edge, and no beat is offered on tlp_valid.
- R3: When cmd_reg[10] (interrupt disable) is set, intx_sts stays low whatever irq_req does.
- R4: When msi_cap_hdr[16] is set, intx_sts stays low; intx_sts and tlp_valid are never high in the same cycle.
- R5: With a 32-bit target, the write is four beats. Beat 0 has [31:29]=3'b010, [28:24]=0, [22:20]=irq_tc and [9:0]=1, with all other bits 0. Beat 1 has [31:16]=req_id, with tag [15:8]=0, last byte enable [7:4]=0 and first byte enable [3:0]=4'hF. Beat 2 is msi_addr_lo with bits [1:0] forced to 0. Beat 3 is the payload.
- R6: A 4-DW header is used only when msi_cap_hdr[23] is set and msi_addr_hi is nonzero. It is five beats: beat 0 has [31:29]=3'b011, beat 2 is msi_addr_hi, beat 3 is the word-aligned msi_addr_lo, and beat 4 is the payload. Otherwise msi_addr_hi is ignored.
- R7: Payload bits [31:16] are 0. Bits [15:0] are msi_data, except that its low n bits are taken from irq_vec, where n = min(msi_cap_hdr[22:20], 5); vector bits at or above n are dropped.
- R8: While tlp_valid is high and tlp_ready is low, tlp_data and tlp_last hold; tlp_last is high only on the final beat.
- R9: irq_ack is a single-cycle pulse in the cycle after the edge that accepted the final beat.
- R10: While cmd_reg[2] (bus master enable) is clear, no write starts; a held request starts one as soon as the bit is seen set.
- R11: The first beat is offered in the cycle after the edge that sampled irq_req high with MSI enabled and bus mastering on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 1 | Interrupt request from the application, level |
| irq_tc | input | 3 | Traffic class for the MSI write |
| irq_vec | input | 5 | Vector number merged into the message data |
| irq_ack | output | 1 | One-cycle acknowledge after an MSI write is sent |
| msi_cap_hdr | input | 32 | MSI capability header dword: [16] enable, [22:20] enabled vectors, [23] 64-bit capable |
| msi_addr_lo | input | 32 | Programmed message address, low dword |
| msi_addr_hi | input | 32 | Programmed message address, high dword |
| msi_data | input | 16 | Programmed message data |
| cmd_reg | input | 16 | Command register: [2] bus master enable, [10] interrupt disable |
| req_id | input | 16 | Requester ID placed in the header |
| tlp_valid | output | 1 | Beat valid toward the transmit path |
| tlp_ready | input | 1 | Transmit path accepts the beat |
| tlp_data | output | 32 | Beat data |
| tlp_last | output | 1 | Final beat of the write |
| intx_sts | output | 1 | Legacy interrupt status level |

## Verification
The assertions assume that the application keeps irq_req high until it sees irq_ack, and drops it in the acknowledge cycle. They also assume that software does not rewrite the capability, address or data inputs while a write is in flight. The bench keeps within this. It changes configuration only between requests, after the previous acknowledge or after a legacy request has been released. Its request task lowers irq_req on the same half-cycle in which it observes the acknowledge. Backpressure on tlp_ready is arbitrary, because the handshake rules place no constraint on the receiver.

// File: rtl/msi_intx_pkg.sv
package msi_intx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_ACK} tx_state_e;

  localparam int CAP_EN_BIT   = 16;
  localparam int CAP_MME_LSB  = 20;
  localparam int CAP_A64_BIT  = 23;
  localparam int CMD_BME_BIT  = 2;
  localparam int CMD_IDIS_BIT = 10;
  localparam int DW           = 32;
  localparam int MAX_BEATS    = 5;

  function automatic logic [DW-1:0] hdr_dw0(input logic four_dw, input logic [2:0] tc);
    logic [2:0] fmt;
    fmt = four_dw ? 3'b011 : 3'b010;
    return {fmt, 5'b00000, 1'b0, tc, 10'd0, 10'd1};
  endfunction
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/msi_payload.sv
module msi_payload #(
  parameter int MSG_W = 16,
  parameter int VEC_W = 5,
  parameter int OUT_W = 32
) (
  input  logic [MSG_W-1:0] msg_data,
  input  logic [VEC_W-1:0] vec,
  input  logic [2:0]       mme,
  output logic [OUT_W-1:0] payload
);
  localparam int NMAX = VEC_W;
  logic [2:0] nsel;

  always_comb begin
    nsel = (int'(mme) > NMAX) ? 3'(NMAX) : mme;
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    if (i < VEC_W && i < MSG_W) begin : g_merge
      assign payload[i] = (int'(nsel) > i) ? vec[i] : msg_data[i];
    end else if (i < MSG_W) begin : g_keep
      assign payload[i] = msg_data[i];
    end else begin : g_zero
      assign payload[i] = 1'b0;
    end
  end
endmodule

// File: rtl/msi_tlp_fsm.sv
module msi_tlp_fsm
  import msi_intx_pkg::*;
#(
  parameter int BEATS = MAX_BEATS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic [BEATS-1:0][DW-1:0]  beats_in,
  input  logic [2:0]                nbeats_in,
  input  logic                      tx_ready,
  output logic                      tx_valid,
  output logic [DW-1:0]             tx_data,
  output logic                      tx_last,
  output logic                      ack
);
  localparam int IDX_W = $clog2(BEATS);

  tx_state_e               st_q, st_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic [BEATS-1:0][DW-1:0] beats_q;
  logic [2:0]              nb_q;
  logic                    load_en;
  logic                    at_end;

  assign at_end = ({1'b0, idx_q} == (nb_q - 3'd1));

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    load_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d    = ST_SEND;
        idx_d   = '0;
        load_en = 1'b1;
      end
      ST_SEND: if (tx_ready) begin
        if (at_end) st_d = ST_ACK;
        else        idx_d = idx_q + 1'b1;
      end
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      beats_q <= beats_in;
      nb_q    <= nbeats_in;
    end
  end

  assign tx_valid = (st_q == ST_SEND);
  assign tx_data  = beats_q[idx_q];
  assign tx_last  = tx_valid && at_end;
  assign ack      = (st_q == ST_ACK);
endmodule

// File: rtl/msi_intx_ctrl.sv
module msi_intx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic msi_on,
  input  logic int_dis,
  output logic intx
);
  logic intx_d;

  always_comb intx_d = req && !msi_on && !int_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intx <= 1'b0;
    else        intx <= intx_d;
  end
endmodule

// File: rtl/msi_intx_gen.sv
module msi_intx_gen
  import msi_intx_pkg::*;
#(
  parameter int TC_W  = 3,
  parameter int VEC_W = 5,
  parameter int MSG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic [TC_W-1:0]  irq_tc,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             irq_ack,
  input  logic [31:0]      msi_cap_hdr,
  input  logic [31:0]      msi_addr_lo,
  input  logic [31:0]      msi_addr_hi,
  input  logic [MSG_W-1:0] msi_data,
  input  logic [15:0]      cmd_reg,
  input  logic [15:0]      req_id,
  output logic             tlp_valid,
  input  logic             tlp_ready,
  output logic [DW-1:0]    tlp_data,
  output logic             tlp_last,
  output logic             intx_sts
);
  logic rst_sync_n;
  logic msi_on, bme, int_dis, a64_cap, four_dw, go;
  logic [2:0] mme;
  logic [DW-1:0] payload;
  logic [MAX_BEATS-1:0][DW-1:0] beats;
  logic [2:0] nbeats;
  logic unused_cfg;

  assign msi_on  = msi_cap_hdr[CAP_EN_BIT];
  assign a64_cap = msi_cap_hdr[CAP_A64_BIT];
  assign mme     = msi_cap_hdr[CAP_MME_LSB +: 3];
  assign bme     = cmd_reg[CMD_BME_BIT];
  assign int_dis = cmd_reg[CMD_IDIS_BIT];
  assign unused_cfg = ^{msi_cap_hdr[31:24], msi_cap_hdr[19:17], msi_cap_hdr[15:0],
                        cmd_reg[15:11], cmd_reg[9:3], cmd_reg[1:0], msi_addr_lo[1:0]};

  assign four_dw = a64_cap && (msi_addr_hi != 32'd0);
  assign go      = irq_req && msi_on && bme;

  msi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  msi_payload #(.MSG_W(MSG_W), .VEC_W(VEC_W), .OUT_W(DW)) u_pay (
    .msg_data (msi_data),
    .vec      (irq_vec),
    .mme      (mme),
    .payload  (payload)
  );

  always_comb begin
    beats[0] = hdr_dw0(four_dw, 3'(irq_tc));
    beats[1] = {req_id, 8'h00, 4'h0, 4'hF};
    if (four_dw) begin
      beats[2] = msi_addr_hi;
      beats[3] = {msi_addr_lo[31:2], 2'b00};
      beats[4] = payload;
      nbeats   = 3'd5;
    end else begin
      beats[2] = {msi_addr_lo[31:2], 2'b00};
      beats[3] = payload;
      beats[4] = '0;
      nbeats   = 3'd4;
    end
  end

  msi_tlp_fsm #(.BEATS(MAX_BEATS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go        (go),
    .beats_in  (beats),
    .nbeats_in (nbeats),
    .tx_ready  (tlp_ready),
    .tx_valid  (tlp_valid),
    .tx_data   (tlp_data),
    .tx_last   (tlp_last),
    .ack       (irq_ack)
  );

  msi_intx_ctrl u_intx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (irq_req),
    .msi_on  (msi_on),
    .int_dis (int_dis),
    .intx    (intx_sts)
  );
endmodule

// File: rtl/msi_intx_gen_chk.sv
module msi_intx_gen_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        irq_req,
  input logic        irq_ack,
  input logic [31:0] msi_cap_hdr,
  input logic [15:0] cmd_reg,
  input logic        tlp_valid,
  input logic        tlp_ready,
  input logic [31:0] tlp_data,
  input logic        tlp_last,
  input logic        intx_sts
);
  // R1: nothing active while internal reset holds
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_ok |-> !irq_ack && !tlp_valid && !intx_sts);

  // R2, R3: legacy level only from a request seen with legacy allowed
  p_intx_source_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    intx_sts |-> $past(irq_req) && !$past(cmd_reg[10]) && !$past(msi_cap_hdr[16]));

  p_one_mechanism_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    !(intx_sts && tlp_valid));

  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    tlp_valid && !tlp_ready |=> tlp_valid && $stable(tlp_data) && $stable(tlp_last));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_ack |=> !irq_ack);

  p_ack_after_last_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_ack |-> $past(tlp_valid && tlp_ready && tlp_last));

  p_start_needs_bme_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(tlp_valid) |-> $past(cmd_reg[2]) && $past(irq_req));
endmodule

bind msi_intx_gen msi_intx_gen_chk u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .irq_req     (irq_req),
  .irq_ack     (irq_ack),
  .msi_cap_hdr (msi_cap_hdr),
  .cmd_reg     (cmd_reg),
  .tlp_valid   (tlp_valid),
  .tlp_ready   (tlp_ready),
  .tlp_data    (tlp_data),
  .tlp_last    (tlp_last),
  .intx_sts    (intx_sts)
);

// File: tb/tb_msi_intx_gen.sv
`timescale 1ns/1ps
module tb_msi_intx_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req;
  logic [2:0]  irq_tc;
  logic [4:0]  irq_vec;
  logic        irq_ack;
  logic [31:0] msi_cap_hdr, msi_addr_lo, msi_addr_hi;
  logic [15:0] msi_data, cmd_reg, req_id;
  logic        tlp_valid, tlp_ready, tlp_last, intx_sts;
  logic [31:0] tlp_data;

  int checks = 0;
  int fails  = 0;
  bit ready_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  msi_intx_gen dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_tc(irq_tc), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .msi_cap_hdr(msi_cap_hdr), .msi_addr_lo(msi_addr_lo),
    .msi_addr_hi(msi_addr_hi), .msi_data(msi_data), .cmd_reg(cmd_reg), .req_id(req_id),
    .tlp_valid(tlp_valid), .tlp_ready(tlp_ready), .tlp_data(tlp_data),
    .tlp_last(tlp_last), .intx_sts(intx_sts)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] mq[$];
  int  mst = 0;           // 0 idle, 1 sending, 2 acknowledge
  bit  ms0 = 0, ms1 = 0;  // reset release pipeline
  bit  mintx = 0;

  function automatic logic [31:0] exp_payload(logic [15:0] d, logic [4:0] v, logic [2:0] m);
    int n;
    logic [15:0] mask;
    n = (m > 5) ? 5 : int'(m);
    mask = 16'((1 << n) - 1);
    return {16'h0000, (d & ~mask) | ({11'h0, v} & mask)};
  endfunction

  task automatic build_write();
    bit wide;
    wide = msi_cap_hdr[23] && (msi_addr_hi != 0);
    mq.delete();
    mq.push_back({wide ? 3'b011 : 3'b010, 5'd0, 1'b0, irq_tc, 10'd0, 10'd1});
    mq.push_back({req_id, 16'h000F});
    if (wide) mq.push_back(msi_addr_hi);
    mq.push_back({msi_addr_lo[31:2], 2'b00});
    mq.push_back(exp_payload(msi_data, irq_vec, msi_cap_hdr[22:20]));
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      ms0 = 0; ms1 = 0; mst = 0; mintx = 0; mq.delete();
    end else begin
      if (ms1) begin
        mintx = irq_req && !msi_cap_hdr[16] && !cmd_reg[10];
        case (mst)
          0: if (irq_req && msi_cap_hdr[16] && cmd_reg[2]) begin build_write(); mst = 1; end
          1: if (tlp_ready) begin void'(mq.pop_front()); if (mq.size() == 0) mst = 2; end
          default: mst = 0;
        endcase
      end
      ms1 = ms0; ms0 = 1;
    end
    check(intx_sts === mintx, "R2 R3 R4 intx", {31'd0, intx_sts}, {31'd0, mintx});
    check(tlp_valid === (mst == 1), "R4 R10 R11 valid", {31'd0, tlp_valid}, {31'd0, mst == 1});
    check(irq_ack === (mst == 2), "R9 ack", {31'd0, irq_ack}, {31'd0, mst == 2});
    if (mst == 1) begin
      check(tlp_data === mq[0], "R5 R6 R7 data", tlp_data, mq[0]);
      check(tlp_last === (mq.size() == 1), "R8 last", {31'd0, tlp_last}, {31'd0, mq.size() == 1});
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tlp_ready <= ready_rand ? lfsr[0] : 1'b1;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic msi_request(input logic [2:0] tc, input logic [4:0] vec);
    int guard = 0;
    @(negedge clk);
    irq_tc = tc; irq_vec = vec; irq_req = 1'b1;
    do begin
      @(negedge clk);
      guard++;
    end while (!irq_ack && guard < 200);
    irq_req = 1'b0;
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0; irq_req = 1'b0; irq_tc = '0; irq_vec = '0;
    msi_cap_hdr = '0; msi_addr_lo = 32'hFEE0_1003; msi_addr_hi = '0;
    msi_data = 16'h4A5B; cmd_reg = 16'h0004; req_id = 16'h0310; tlp_ready = 1'b1;
    idle(3);
    // R1: outputs quiet in reset
    check(!irq_ack && !tlp_valid && !intx_sts, "R1 reset", {29'd0, irq_ack, tlp_valid, intx_sts}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(!irq_ack && !tlp_valid && !intx_sts, "R1 release", {29'd0, irq_ack, tlp_valid, intx_sts}, 32'd0);
    idle(3);

    // R2: legacy level follows request
    irq_req = 1'b1; idle(6); irq_req = 1'b0; idle(3);
    // R3: interrupt disable masks the level
    cmd_reg = 16'h0404; irq_req = 1'b1; idle(5); irq_req = 1'b0; idle(2);
    cmd_reg = 16'h0004;

    // R4 R5 R11: MSI, 32-bit target, single vector
    msi_cap_hdr = 32'h0001_0000;
    msi_request(3'd3, 5'd7);
    // R7: four vectors, random backpressure (R8)
    ready_rand = 1'b1;
    msi_cap_hdr = 32'h0021_0000;
    msi_request(3'd5, 5'd13);
    // R6: wide address with nonzero upper dword
    msi_cap_hdr = 32'h00B1_0000; msi_addr_hi = 32'h0000_0001;
    msi_request(3'd1, 5'd2);
    // R6: capable but upper zero stays 3DW
    msi_addr_hi = 32'h0; msi_request(3'd0, 5'd1);
    // R6: not capable, upper ignored
    msi_cap_hdr = 32'h0031_0000; msi_addr_hi = 32'hDEAD_0000;
    msi_request(3'd7, 5'd31);
    // R7: field above 5 clamps to five bits
    msi_cap_hdr = 32'h0071_0000; msi_data = 16'hFFFF;
    msi_request(3'd2, 5'd10);
    msi_cap_hdr = 32'h0051_0000; msi_data = 16'h0000;
    msi_request(3'd4, 5'd31);
    // R10: bus master clear holds the request
    ready_rand = 1'b0;
    cmd_reg = 16'h0000;
    @(negedge clk); irq_tc = 3'd6; irq_vec = 5'd3; irq_req = 1'b1;
    idle(8);
    cmd_reg = 16'h0004;
    begin
      int guard = 0;
      do begin @(negedge clk); guard++; end while (!irq_ack && guard < 200);
      check(guard < 200, "R10 held request sent", guard, 32'd0);
    end
    irq_req = 1'b0; idle(2);
    // R4: legacy request while MSI on, with ack drop behaviour
    ready_rand = 1'b1;
    msi_cap_hdr = 32'h0001_0000; msi_addr_hi = 32'h0000_00FF;
    msi_cap_hdr[23] = 1'b1;
    msi_request(3'd1, 5'd0);
    // back to legacy
    msi_cap_hdr = 32'h0; irq_req = 1'b1; idle(4); irq_req = 1'b0; idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule